// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Level Generator

This block turns a signed modulating sample into the level command for one phase leg of a five-level inverter. One triangular sweep counter is mapped onto four carriers that sit in contiguous vertical bands covering the whole modulating range. The carriers all share one frequency and one peak-to-peak span, and each carrier runs in the opposite phase to the band next to it. Each carrier is compared against the held sample. Every comparison counts as +1 when the sample is strictly above the carrier and as -1 otherwise. The four results are added, halved and registered. The result is a signed level from -2 to +2, and the leg follows this level.

The carrier half-period is set by an input in clock cycles, so the ratio of carrier frequency to modulating frequency follows from how fast the external source updates its sine. The modulating input is taken only at the top of the sweep (regular sampling), once per carrier period. A commutation counter counts every change of the output level. A cycle-start strobe copies the running count to the output and begins a new count. This lets a controller read how many transitions happened in one modulating cycle.

The sweep is a two-state machine. In SWEEP_UP the counter rises by one per cycle. The transition turn-at-peak moves it to SWEEP_DOWN in the cycle where the counter has reached the half-period. In SWEEP_DOWN the counter falls. The transition turn-at-valley moves it back to SWEEP_UP in the cycle where the counter is zero, and this is the only moment a new half-period setting is accepted.

Top module: `mlpwm_level_gen`

## Requirements
- R1: The sweep counter follows 0,1,..,H,H-1,..,1,0,1,.. with a period of 2H cycles. H is the half-period input, and a value of 0 is treated as 1. H is loaded at reset and at each valley (turn-at-valley), and is held everywhere else.
- R2: Band k (k = 0 lowest .. 3 highest) has carrier (k-2)*H + c for even k and (k-2)*H + (H-c) for odd k, where c is the sweep counter. The bands therefore tile -2H..+2H, and neighbouring bands move in opposite directions.
- R3: A band contributes +1 when the held sample is strictly greater than its carrier and -1 otherwise, so a sample equal to a carrier contributes -1.
- R4: The level output is the sum of the four contributions divided by 2. It is a 3-bit two's-complement value in -2..+2, registered, and appears one clock after the counter value and held sample it was formed from.
- R5: The modulating input is captured only in a cycle where the state is SWEEP_UP and the counter equals H. Changes of the input at any other time have no effect on the level.
- R6: A held sample above +2H gives a constant level of +2. A held sample at or below -2H gives a constant level of -2.
- R7: A running count increases by one on every clock edge at which the level changes. On an edge with the cycle-start strobe high, the commutation output takes the running count, and the running count restarts from the change, if any, made at that same edge. The commutation output is held between strobes.
- R8: With the held sample constant and strictly inside one band (never at a band edge), a strobe window of Mf full carrier periods reports 2*Mf commutations.
- R9: While reset is high, the level output and the commutation output are 0, the sweep counter is 0 in SWEEP_UP, and the held sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_in | input | CW (12) | Carrier half-period H in cycles |
| mod_in | input | MW (14) | Signed modulating sample |
| cycle_start | input | 1 | Strobe marking the start of a modulating cycle |
| level | output | 3 | Signed level command, -2..+2 |
| commutations | output | CNTW (16) | Level changes counted in the last strobe window |

## Verification
Two events can land on the same clock edge: the cycle-start strobe that closes a window, and a level change. The strobe is also issued at arbitrary sweep phases during the band sweeps, so it often coincides with a crossing. A bench model counts such an edge into the new window and checks the reported count against that rule at every cycle. In the same way, the peak capture of a new sample can coincide with a crossing in another band. Driving a different value on every cycle provokes this, and the level is judged against an arithmetic model of the four stacked carriers.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    typedef enum logic [0:0] {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_e;

    localparam int NBANDS = 4;

endpackage

// File: rtl/mlpwm_sweep.sv
module mlpwm_sweep
    import mlpwm_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] period_in,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] half,
    output logic          peak
);

    sweep_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] half_q, half_d;
    logic [CW-1:0] half_clamped;

    assign half_clamped = (period_in == '0) ? CW'(1) : period_in;

    // next-state and next-count decode
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        half_d  = half_q;
        unique case (state_q)
            SWEEP_UP: begin
                if (cnt_q >= half_q) begin
                    state_d = SWEEP_DOWN;
                    cnt_d   = cnt_q - CW'(1);
                end else begin
                    cnt_d   = cnt_q + CW'(1);
                end
            end
            SWEEP_DOWN: begin
                if (cnt_q == '0) begin
                    state_d = SWEEP_UP;
                    cnt_d   = CW'(1);
                    half_d  = half_clamped;
                end else begin
                    cnt_d   = cnt_q - CW'(1);
                end
            end
            default: begin
                state_d = SWEEP_UP;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SWEEP_UP;
            cnt_q   <= '0;
            half_q  <= half_clamped;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            half_q  <= half_d;
        end
    end

    // outputs
    always_comb begin
        cnt  = cnt_q;
        half = half_q;
        peak = (state_q == SWEEP_UP) && (cnt_q == half_q);
    end

    assert_cnt_within_half_R1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= half_q);

    assert_rise_step_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == SWEEP_UP && cnt_q < half_q) |=> (cnt_q == $past(cnt_q) + CW'(1)));

    assert_half_held_R1: assert property (@(posedge clk) disable iff (rst)
        !(state_q == SWEEP_DOWN && cnt_q == '0) |=> $stable(half_q));

endmodule

// File: rtl/mlpwm_bands.sv
module mlpwm_bands
    import mlpwm_pkg::*;
#(
    parameter int CW = 12,
    parameter int MW = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CW-1:0]        cnt,
    input  logic [CW-1:0]        half,
    input  logic                 peak,
    input  logic signed [MW-1:0] mod_in,
    output logic signed [2:0]    level_q,
    output logic signed [2:0]    level_nxt
);

    localparam int PADW = MW - CW;

    logic signed [MW-1:0] h_s, c_s;
    logic signed [MW-1:0] mod_q;
    logic signed [MW-1:0] car [NBANDS];
    logic [NBANDS-1:0]    above;
    logic signed [3:0]    vote_sum;

    assign h_s = $signed({{PADW{1'b0}}, half});
    assign c_s = $signed({{PADW{1'b0}}, cnt});

    for (genvar k = 0; k < NBANDS; k++) begin : g_band
        localparam logic signed [MW-1:0] OFS = MW'(k - NBANDS / 2);
        if ((k % 2) == 0) begin : g_rise
            assign car[k] = OFS * h_s + c_s;
        end else begin : g_fall
            assign car[k] = OFS * h_s + (h_s - c_s);
        end
        assign above[k] = (mod_q > car[k]);
    end

    always_comb begin
        vote_sum = '0;
        for (int k = 0; k < NBANDS; k++) begin
            vote_sum = above[k] ? (vote_sum + 4'sd1) : (vote_sum - 4'sd1);
        end
        level_nxt = 3'(vote_sum >>> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_q   <= '0;
            level_q <= '0;
        end else begin
            if (peak) begin
                mod_q <= mod_in;
            end
            level_q <= level_nxt;
        end
    end

    assert_level_range_R4: assert property (@(posedge clk) disable iff (rst)
        (level_q >= -3'sd2) && (level_q <= 3'sd2));

    assert_sample_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !peak |=> $stable(mod_q));

    assert_overmod_top_R6: assert property (@(posedge clk) disable iff (rst)
        (mod_q > (h_s + h_s)) |=> (level_q == 3'sd2));

    assert_overmod_bottom_R6: assert property (@(posedge clk) disable iff (rst)
        (mod_q <= -(h_s + h_s)) |=> (level_q == -3'sd2));

endmodule

// File: rtl/mlpwm_commut.sv
module mlpwm_commut #(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe,
    input  logic            change,
    output logic [CNTW-1:0] count_q
);

    logic [CNTW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            count_q <= '0;
        end else if (strobe) begin
            count_q <= run_q;
            run_q   <= change ? CNTW'(1) : '0;
        end else if (change) begin
            run_q   <= run_q + CNTW'(1);
        end
    end

    assert_window_latch_R7: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (count_q == $past(run_q)));

    assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(count_q));

endmodule

// File: rtl/mlpwm_level_gen.sv
module mlpwm_level_gen
    import mlpwm_pkg::*;
#(
    parameter int CW   = 12,
    parameter int MW   = 14,
    parameter int CNTW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CW-1:0]        period_in,
    input  logic signed [MW-1:0] mod_in,
    input  logic                 cycle_start,
    output logic signed [2:0]    level,
    output logic [CNTW-1:0]      commutations
);

    logic [CW-1:0]     sw_cnt, sw_half;
    logic              sw_peak;
    logic signed [2:0] lvl_q, lvl_nxt;

    mlpwm_sweep #(.CW(CW)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .period_in (period_in),
        .cnt       (sw_cnt),
        .half      (sw_half),
        .peak      (sw_peak)
    );

    mlpwm_bands #(.CW(CW), .MW(MW)) u_bands (
        .clk       (clk),
        .rst       (rst),
        .cnt       (sw_cnt),
        .half      (sw_half),
        .peak      (sw_peak),
        .mod_in    (mod_in),
        .level_q   (lvl_q),
        .level_nxt (lvl_nxt)
    );

    mlpwm_commut #(.CNTW(CNTW)) u_commut (
        .clk     (clk),
        .rst     (rst),
        .strobe  (cycle_start),
        .change  (lvl_nxt != lvl_q),
        .count_q (commutations)
    );

    assign level = lvl_q;

    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (level == 3'sd0 && commutations == '0));

endmodule

// File: tb/mlpwm_level_gen_bench.sv
module mlpwm_level_gen_bench;

    localparam int TCLK = 10;
    localparam int CW = 12, MW = 14, CNTW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [CW-1:0]        period_in = CW'(8);
    logic signed [MW-1:0] mod_in = '0;
    logic                 cycle_start = 1'b0;
    logic signed [2:0]    level;
    logic [CNTW-1:0]      commutations;

    int n_chk = 0, n_err = 0;
    bit tracking = 1'b0, done = 1'b0;
    string tag = "R2/R3/R4";

    int m_cnt, m_h, m_mod, m_lvl, m_run, m_lat, cyc;
    bit m_up;

    always #(TCLK/2) clk = ~clk;

    mlpwm_level_gen #(.CW(CW), .MW(MW), .CNTW(CNTW)) u_mlpwm_level_gen (
        .clk(clk), .rst(rst), .period_in(period_in), .mod_in(mod_in),
        .cycle_start(cycle_start), .level(level), .commutations(commutations)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clampv(int p);
        return (p == 0) ? 1 : p;
    endfunction

    // R2/R3/R4 arithmetic model of the stacked carriers
    function automatic int exp_level(int v, int c, int h);
        int s = 0;
        for (int k = 0; k < 4; k++) begin
            int car = (k - 2) * h + (((k % 2) == 0) ? c : (h - c));
            s += (v > car) ? 1 : -1;
        end
        return s / 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_up = 1'b1; m_h = clampv(int'(period_in));
            m_mod = 0; m_lvl = 0; m_run = 0; m_lat = 0;
        end else begin
            int nl;
            bit chg;
            nl  = exp_level(m_mod, m_cnt, m_h);
            chg = (nl != m_lvl);
            if (cycle_start) begin m_lat = m_run; m_run = chg ? 1 : 0; end
            else m_run += chg ? 1 : 0;
            m_lvl = nl;
            if (m_up && m_cnt == m_h) m_mod = int'(mod_in);
            if (m_up) begin
                if (m_cnt >= m_h) begin m_up = 1'b0; m_cnt--; end else m_cnt++;
            end else begin
                if (m_cnt == 0) begin m_up = 1'b1; m_cnt = 1; m_h = clampv(int'(period_in)); end
                else m_cnt--;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && tracking && !done) begin
            chk(int'(level) == m_lvl, tag, int'(level), m_lvl);
            chk(int'(commutations) == m_lat, "R7", int'(commutations), m_lat);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !done) begin
                chk(1'b0, "watchdog", cyc, 100000);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(level == 3'sd0, "R9", int'(level), 0);
        chk(commutations == '0, "R9", int'(commutations), 0);
        @(negedge clk);
        rst = 1'b0;
        tracking = 1'b1;

        // R2/R3/R4/R6: constant samples across and beyond the band stack, H = 8
        tag = "R2/R3/R4";
        for (int v = -18; v <= 18; v++) begin
            mod_in = MW'(v);
            repeat (64) @(negedge clk);
            if (v > 16)   chk(level == 3'sd2,  "R6", int'(level), 2);
            if (v <= -16) chk(level == -3'sd2, "R6", int'(level), -2);
        end

        // R5: input changing every cycle, only peak values may matter
        tag = "R5";
        period_in = CW'(5);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            mod_in = MW'(((i * 37 + 11) % 41) - 20);
            cycle_start = ((i % 13) == 0);
        end
        @(negedge clk);
        cycle_start = 1'b0;

        // R1: half-period changes, including a zero setting
        tag = "R1";
        period_in = CW'(3);
        for (int i = 0; i < 100; i++) begin @(negedge clk); mod_in = MW'((i % 15) - 7); end
        period_in = '0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); mod_in = MW'((i % 5) - 2); end
        period_in = CW'(6);
        for (int i = 0; i < 100; i++) begin @(negedge clk); mod_in = MW'((i % 25) - 12); end

        // R8: interior samples give 2*Mf commutations per Mf carrier periods
        tag = "R2/R3/R4";
        period_in = CW'(8);
        for (int mf = 2; mf <= 5; mf++) begin
            for (int j = 0; j < 4; j++) begin
                int v = (j == 0) ? -12 : (j == 1) ? -5 : (j == 2) ? 3 : 13;
                mod_in = MW'(v);
                repeat (64) @(negedge clk);
                cycle_start = 1'b1;
                @(negedge clk);
                cycle_start = 1'b0;
                repeat (mf * 16 - 1) @(negedge clk);
                cycle_start = 1'b1;
                @(negedge clk);
                cycle_start = 1'b0;
                chk(int'(commutations) == 2 * mf, "R8", int'(commutations), 2 * mf);
            end
        end

        finish_run();
    end

endmodule